// File: doc/BRIEF.md
# AUX completion status classifier

This block sits beside the command engine of an auxiliary-channel controller for a display link. A transaction is opened with a start strobe that also says whether it is a native transfer or an I2C-over-AUX transfer. While the transaction is busy, one strobed word of raw completion status is turned into a result code and a reply class. The status word has seven flags: done, wrong address, timeout, NACK-or-defer, I2C NACK, I2C defer and PHY error. Native and I2C transfers use different priority chains. In both chains, later conditions override earlier ones.

If no status arrives within a parameterised number of cycles, a watchdog closes the transaction as a timeout. When the link is reported as connected, that expiry also pulses a channel reset. Consecutive native expiries are counted, and each fifth one pulses a reconfigure request. Any completion that comes from a status word clears the count. Results are registered and held until the next transaction starts.

Top module: `aux_status_classifier`

## Requirements
- R1: Reset state: busy, result_valid, expired, status_clear, reconfig and aux_reset are 0. The result code is NONE and the reply class is ACK.
- R2: A start is accepted only while idle. busy is high from the next cycle, and at that edge the code is cleared to NONE and the reply to ACK. A start while busy is ignored, and the native/I2C choice made first is kept.
- R3: A status strobe while idle is ignored, and every output keeps its value.
- R4: The status word bit positions are done=0, wrong address=1, timeout=2, NACK-or-defer=3, I2C NACK=4, I2C defer=5 and PHY=6. The result codes are NONE=0, ADDR=1, TOUT=2, NACK=3, DEFER=4, NACK_DEFER=5 and PHY=6. A native transfer is classified as follows. Done gives NONE; otherwise wrong address gives ADDR; otherwise timeout gives TOUT. NACK-or-defer then overrides the result with NACK, and PHY overrides everything with PHY. With no flag set, the result is NONE.
- R5: For an I2C transfer with done set, the result is NACK if I2C NACK or I2C defer is also set, and NONE otherwise. All other flags are ignored, including PHY.
- R6: For an I2C transfer without done, the rules apply in this order, each later rule overriding earlier ones. First, ADDR or TOUT is chosen as in R4. Then NACK-or-defer gives NACK_DEFER, I2C NACK gives NACK, I2C defer gives DEFER and PHY gives PHY. With no flag set, the result is NONE.
- R7: The reply classes are ACK=0, NACK=1, DEFER=2 and TIMEOUT=3. NONE maps to ACK and DEFER maps to DEFER. TOUT maps to TIMEOUT. ADDR, NACK, NACK_DEFER and PHY map to NACK.
- R8: status_clear pulses for one cycle, together with result_valid, exactly when a status strobe yields PHY.
- R9: result_valid pulses for one cycle, one clock after the status edge, and busy drops in the same cycle. The code, reply and expired flag hold until the next accepted start.
- R10: A transaction with no status strobe on any of the TIMEOUT_CYCLES edges after its start completes with code TOUT, reply TIMEOUT and expired=1. A strobe on the last of those edges still wins.
- R11: Each native expiry increments a retry count. When the count reaches RETRY_LIMIT, reconfig pulses together with that result and the count restarts. A status-strobe completion clears the count, and an I2C expiry leaves it unchanged.
- R12: aux_reset pulses together with an expiry result exactly when link_connected was high at the expiry edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Open a transaction (accepted only when idle) |
| txn_native | input | 1 | 1 = native transfer, 0 = I2C-over-AUX, sampled with an accepted start |
| irq_valid | input | 1 | Status word strobe |
| irq_status | input | 7 | Raw completion flags, positions as in R4 |
| link_connected | input | 1 | Link connection state used on expiry |
| busy | output | 1 | Transaction in flight |
| result_valid | output | 1 | One-cycle completion pulse |
| result_code | output | 3 | Registered result code |
| reply_class | output | 2 | Registered reply class |
| expired | output | 1 | Last result came from the watchdog |
| status_clear | output | 1 | Pulse requesting a clear of interrupt status |
| reconfig | output | 1 | Pulse requesting a channel reconfiguration |
| aux_reset | output | 1 | Pulse requesting a channel reset |

## Verification
Every output is registered. A start sampled at edge k shows busy after edge k. A status strobe sampled at edge j shows its code, reply, status_clear and result_valid after edge j. The watchdog result and its reconfig and aux_reset pulses appear after edge k+TIMEOUT_CYCLES. The bench drives inputs on falling edges and updates a behavioural model on rising edges. It compares every output against that model at the following falling edge, so each result is sampled in the half cycle just after the edge it is due at.

// File: rtl/aux_cls_pkg.sv
package aux_cls_pkg;

  localparam int unsigned STAT_W = 7;

  typedef struct packed {
    logic phy;
    logic i2c_defer;
    logic i2c_nack;
    logic nack_defer;
    logic tout;
    logic waddr;
    logic done;
  } stat_t;

  typedef enum logic [2:0] {
    RES_NONE       = 3'd0,
    RES_ADDR       = 3'd1,
    RES_TOUT       = 3'd2,
    RES_NACK       = 3'd3,
    RES_DEFER      = 3'd4,
    RES_NACK_DEFER = 3'd5,
    RES_PHY        = 3'd6
  } res_e;

  typedef enum logic [1:0] {
    RPL_ACK     = 2'd0,
    RPL_NACK    = 2'd1,
    RPL_DEFER   = 2'd2,
    RPL_TIMEOUT = 2'd3
  } rpl_e;

  // Shared front of both chains: wrong address beats timeout.
  function automatic res_e base_error(stat_t s);
    res_e r;
    r = RES_NONE;
    if (s.waddr)     r = RES_ADDR;
    else if (s.tout) r = RES_TOUT;
    return r;
  endfunction

  function automatic res_e classify_native(stat_t s);
    res_e r;
    r = s.done ? RES_NONE : base_error(s);
    if (s.nack_defer) r = RES_NACK;
    if (s.phy)        r = RES_PHY;
    return r;
  endfunction

  function automatic res_e classify_i2c(stat_t s);
    res_e r;
    if (s.done) begin
      r = (s.i2c_nack || s.i2c_defer) ? RES_NACK : RES_NONE;
    end else begin
      r = base_error(s);
      if (s.nack_defer) r = RES_NACK_DEFER;
      if (s.i2c_nack)   r = RES_NACK;
      if (s.i2c_defer)  r = RES_DEFER;
      if (s.phy)        r = RES_PHY;
    end
    return r;
  endfunction

  function automatic rpl_e reply_of(res_e r);
    rpl_e p;
    unique case (r)
      RES_NONE:  p = RPL_ACK;
      RES_DEFER: p = RPL_DEFER;
      RES_TOUT:  p = RPL_TIMEOUT;
      default:   p = RPL_NACK;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/aux_cls_decode.sv
module aux_cls_decode
  import aux_cls_pkg::*;
(
  input  logic [STAT_W-1:0] stat_raw,
  input  logic              is_native,
  output res_e              code,
  output rpl_e              reply,
  output logic              clr_req
);

  stat_t s;
  res_e  native_code;
  res_e  i2c_code;

  assign s = stat_t'(stat_raw);

  always_comb begin
    native_code = classify_native(s);
    i2c_code    = classify_i2c(s);
  end

  always_comb begin
    code    = is_native ? native_code : i2c_code;
    reply   = reply_of(code);
    clr_req = (code == RES_PHY);
  end

endmodule

// File: rtl/aux_cls_watchdog.sv
module aux_cls_watchdog #(
  parameter int unsigned LIMIT = 62_500_000,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic active,
  output logic hit
);

  logic [CW-1:0] age;

  assign hit = active && (age == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)              age <= '0;
    else if (arm)            age <= '0;
    else if (active && !hit) age <= age + CW'(1);
  end

endmodule

// File: rtl/aux_cls_retry.sv
module aux_cls_retry #(
  parameter int unsigned LIMIT = 5,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail,
  input  logic clear,
  output logic hit
);

  logic [CW-1:0] tally;

  assign hit = fail && (tally == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)     tally <= '0;
    else if (clear) tally <= '0;
    else if (fail)  tally <= hit ? '0 : tally + CW'(1);
  end

endmodule

// File: rtl/aux_status_classifier.sv
module aux_status_classifier
  import aux_cls_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 62_500_000,
  parameter int unsigned RETRY_LIMIT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic              txn_native,
  input  logic              irq_valid,
  input  logic [STAT_W-1:0] irq_status,
  input  logic              link_connected,
  output logic              busy,
  output logic              result_valid,
  output logic [2:0]        result_code,
  output logic [1:0]        reply_class,
  output logic              expired,
  output logic              status_clear,
  output logic              reconfig,
  output logic              aux_reset
);

  logic busy_q, native_q;
  res_e code_q;
  rpl_e reply_q;
  logic valid_q, exp_q, clr_q, rcf_q, rst_q;

  // Named internal events, visible to the checker and waveforms.
  logic start_acc, status_evt, wd_hit, wd_expire, finish, retry_hit;
  res_e dec_code;
  rpl_e dec_reply;
  logic dec_clr;

  assign start_acc  = txn_start && !busy_q;
  assign status_evt = busy_q && irq_valid;
  assign wd_expire  = wd_hit && !status_evt;
  assign finish     = status_evt || wd_expire;

  aux_cls_decode u_dec (
    .stat_raw  (irq_status),
    .is_native (native_q),
    .code      (dec_code),
    .reply     (dec_reply),
    .clr_req   (dec_clr)
  );

  aux_cls_watchdog #(.LIMIT(TIMEOUT_CYCLES)) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (start_acc),
    .active (busy_q),
    .hit    (wd_hit)
  );

  aux_cls_retry #(.LIMIT(RETRY_LIMIT)) u_retry (
    .clk   (clk),
    .rst_n (rst_n),
    .fail  (wd_expire && native_q),
    .clear (status_evt),
    .hit   (retry_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      native_q <= 1'b0;
      code_q   <= RES_NONE;
      reply_q  <= RPL_ACK;
      valid_q  <= 1'b0;
      exp_q    <= 1'b0;
      clr_q    <= 1'b0;
      rcf_q    <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      valid_q <= finish;
      clr_q   <= status_evt && dec_clr;
      rcf_q   <= wd_expire && native_q && retry_hit;
      rst_q   <= wd_expire && link_connected;
      if (start_acc) begin
        busy_q   <= 1'b1;
        native_q <= txn_native;
        code_q   <= RES_NONE;
        reply_q  <= RPL_ACK;
        exp_q    <= 1'b0;
      end else if (finish) begin
        busy_q  <= 1'b0;
        code_q  <= status_evt ? dec_code  : RES_TOUT;
        reply_q <= status_evt ? dec_reply : RPL_TIMEOUT;
        exp_q   <= wd_expire;
      end
    end
  end

  assign busy         = busy_q;
  assign result_valid = valid_q;
  assign result_code  = code_q;
  assign reply_class  = reply_q;
  assign expired      = exp_q;
  assign status_clear = clr_q;
  assign reconfig     = rcf_q;
  assign aux_reset    = rst_q;

endmodule

// File: rtl/aux_cls_checker.sv
module aux_cls_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       txn_start,
  input logic       link_connected,
  input logic       busy,
  input logic       result_valid,
  input logic [2:0] result_code,
  input logic [1:0] reply_class,
  input logic       expired,
  input logic       status_clear,
  input logic       reconfig,
  input logic       aux_reset
);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (result_code == 3'd0 && reply_class == 2'd0 && !result_valid)); // R2

  AST_RESULT_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> ($past(busy) && !busy)); // R9

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(result_code) && $stable(reply_class))); // R9

  AST_PHY_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && result_code == 3'd6) |-> reply_class == 2'd1); // R7

  AST_CLEAR_ON_PHY: assert property (@(posedge clk) disable iff (!rst_n)
    status_clear |-> (result_valid && result_code == 3'd6 && !expired)); // R8

  AST_EXPIRY_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && expired) |-> (result_code == 3'd2 && reply_class == 2'd3)); // R10

  AST_RECONFIG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig |-> (result_valid && expired)); // R11

  AST_RESET_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    aux_reset |-> (result_valid && expired && $past(link_connected))); // R12

endmodule

bind aux_status_classifier aux_cls_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .txn_start      (txn_start),
  .link_connected (link_connected),
  .busy           (busy),
  .result_valid   (result_valid),
  .result_code    (result_code),
  .reply_class    (reply_class),
  .expired        (expired),
  .status_clear   (status_clear),
  .reconfig       (reconfig),
  .aux_reset      (aux_reset)
);

// File: tb/aux_status_classifier_test.sv
`timescale 1ns/1ps
module aux_status_classifier_test;

  localparam int TMO  = 12;
  localparam int RLIM = 5;
  localparam int B_DONE = 0, B_ADDR = 1, B_TOUT = 2, B_ND = 3, B_INACK = 4, B_IDEF = 5, B_PHY = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txn_start = 1'b0, txn_native = 1'b0, irq_valid = 1'b0, link_connected = 1'b0;
  logic [6:0] irq_status = '0;
  logic busy, result_valid, expired, status_clear, reconfig, aux_reset;
  logic [2:0] result_code;
  logic [1:0] reply_class;

  int n_cmp = 0, n_bad = 0;
  bit armed = 0;

  always #2 clk = ~clk;

  aux_status_classifier #(.TIMEOUT_CYCLES(TMO), .RETRY_LIMIT(RLIM)) uut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_native(txn_native),
    .irq_valid(irq_valid), .irq_status(irq_status), .link_connected(link_connected),
    .busy(busy), .result_valid(result_valid), .result_code(result_code),
    .reply_class(reply_class), .expired(expired), .status_clear(status_clear),
    .reconfig(reconfig), .aux_reset(aux_reset)
  );

  // Behavioural reference model
  bit m_busy, m_native, m_valid, m_exp, m_clr, m_rcf, m_ars;
  int m_code, m_reply, m_age, m_fails;

  function automatic int ref_code(bit nat, logic [6:0] s);
    int c = 0;
    if (nat) begin
      if (!s[B_DONE]) c = s[B_ADDR] ? 1 : (s[B_TOUT] ? 2 : 0);
      if (s[B_ND])  c = 3;
      if (s[B_PHY]) c = 6;
    end else if (s[B_DONE]) begin
      c = (s[B_INACK] | s[B_IDEF]) ? 3 : 0;
    end else begin
      c = s[B_ADDR] ? 1 : (s[B_TOUT] ? 2 : 0);
      if (s[B_ND])    c = 5;
      if (s[B_INACK]) c = 3;
      if (s[B_IDEF])  c = 4;
      if (s[B_PHY])   c = 6;
    end
    return c;
  endfunction

  function automatic int ref_reply(int c);
    if (c == 0) return 0;
    if (c == 4) return 2;
    if (c == 2) return 3;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_native = 0; m_valid = 0; m_exp = 0; m_clr = 0; m_rcf = 0; m_ars = 0;
      m_code = 0; m_reply = 0; m_age = 0; m_fails = 0;
    end else begin
      m_valid = 0; m_clr = 0; m_rcf = 0; m_ars = 0;
      if (m_busy) begin
        m_age++;
        if (irq_valid) begin
          m_code = ref_code(m_native, irq_status); m_reply = ref_reply(m_code);
          m_valid = 1; m_busy = 0; m_exp = 0; m_clr = (m_code == 6); m_fails = 0;
        end else if (m_age == TMO) begin
          m_code = 2; m_reply = 3; m_valid = 1; m_busy = 0; m_exp = 1; m_ars = link_connected;
          if (m_native) begin
            m_fails++;
            if (m_fails == RLIM) begin m_rcf = 1; m_fails = 0; end
          end
        end
      end else if (txn_start) begin
        m_busy = 1; m_native = txn_native; m_age = 0; m_code = 0; m_reply = 0; m_exp = 0;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (armed) begin
    chk("R2 busy", int'(busy), int'(m_busy));
    chk("R9 result_valid", int'(result_valid), int'(m_valid));
    chk("R4 R5 R6 result_code", int'(result_code), m_code);
    chk("R7 reply_class", int'(reply_class), m_reply);
    chk("R10 expired", int'(expired), int'(m_exp));
    chk("R8 status_clear", int'(status_clear), int'(m_clr));
    chk("R11 reconfig", int'(reconfig), int'(m_rcf));
    chk("R12 aux_reset", int'(aux_reset), int'(m_ars));
  end

  task automatic start(bit nat);
    @(negedge clk); txn_start = 1; txn_native = nat;
    @(negedge clk); txn_start = 0;
  endtask

  task automatic irq(logic [6:0] bits);
    @(negedge clk); irq_valid = 1; irq_status = bits;
    @(negedge clk); irq_valid = 0; irq_status = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic txn(bit nat, logic [6:0] bits);
    start(nat); idle(1); irq(bits); idle(1);
  endtask

  task automatic expire(bit nat, bit link);
    link_connected = link; start(nat); idle(TMO + 2);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset code", int'(result_code), 0);
    chk("R1 reset reply", int'(reply_class), 0);
    chk("R1 reset pulses", int'({result_valid, expired, status_clear, reconfig, aux_reset}), 0);
    armed = 1;
    rst_n = 1;
    idle(2);
    // R4 native chain
    txn(1, 7'b0000001); txn(1, 7'b0000010); txn(1, 7'b0000100); txn(1, 7'b0000110);
    txn(1, 7'b0001001); txn(1, 7'b0001100); txn(1, 7'b1000001); txn(1, 7'b0000000);
    // R5 I2C with done
    txn(0, 7'b0000001); txn(0, 7'b0010001); txn(0, 7'b0100001); txn(0, 7'b1000001);
    chk("R5 done with phy gives NONE", int'(result_code), 0);
    // R6 I2C without done
    txn(0, 7'b0000010); txn(0, 7'b0001100); txn(0, 7'b0011000); txn(0, 7'b0110000);
    txn(0, 7'b1001000); txn(0, 7'b0100010); txn(0, 7'b0000000);
    // R3 status while idle
    irq(7'b1000010); idle(1);
    chk("R3 idle strobe code", int'(result_code), 0);
    chk("R3 idle strobe valid", int'(result_valid | status_clear), 0);
    // R2 start while busy keeps native choice
    start(1); start(0); irq(7'b0001000); idle(1);
    chk("R2 second start ignored", int'(result_code), 3);
    // R10 strobe on last edge wins
    start(1); idle(TMO - 2); irq(7'b0100000); idle(2);
    // R11 R12 expiries
    expire(1, 1); expire(1, 0); expire(1, 1);
    txn(1, 7'b0000001);
    expire(1, 1); expire(0, 1); expire(1, 0); expire(1, 1); expire(1, 0);
    expire(1, 1);
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule